// File: doc/BRIEF.md
# Serial Programming Command Decoder

This block interprets four-byte serial commands that load and verify on-chip code and data memories while the device is held in programming mode. An external programmer drives a shift clock and a data-in line. The block oversamples both lines in the system clock domain and collects each command MSB first. It then turns the command into single-cycle requests on a simple memory port. The memory side owns the arrays and all page-write timing. On a read, the returned byte goes out on the data-out line during the last byte of the same frame.

The block ignores every command until an enable handshake has been seen in the current programming session. Leaving programming mode clears that handshake and drops any frame that was only partly shifted. Two sticky protection bits limit what the programmer can do. The first blocks all writes, and both together also block read-back. Only a full erase clears them. A read at two fixed offsets in the signature space returns a constant identity pair.

Top module: `isp_cmd_decoder`

## Requirements
- R1: A frame is 32 bits. SDI is sampled on rising edges of SCK (idle low), MSB first, and bytes are numbered 1 to 4 in arrival order. During byte 4, SDO carries the reply MSB first and advances on each falling SCK edge. Outside byte 4, SDO is 0.
- R2: The enable command has byte 1 = ACh and byte 2 = 53h. Until it has completed in the current session, every other command issues no request and replies 00h.
- R3: While prog_mode_i is low, the bit and byte position returns to the start of a frame and the enable state is cleared. A partial frame is discarded, and the next frame after prog_mode_i rises is aligned from its first bit.
- R4: Code read has byte 1 = 20h and code write has byte 1 = 40h. The 12-bit address is {byte2[3:0], byte3}. A read replies with the memory byte. A write passes byte 4 as write data.
- R5: Data read has byte 1 = A0h/A1h and data write has byte 1 = C0h/C1h. The 17-bit address is {byte1[0], byte2, byte3}, and mem_space_o = 1 selects the data array.
- R6: Signature read has byte 1 = 30h. An offset byte3[6:0] of 30h replies 1Eh, 31h replies 84h, and any other offset replies 00h.
- R7: Chip erase (ACh, 80h) issues one mem_erase_o pulse and returns both protection bits to unprogrammed.
- R8: Protection programming (ACh, byte 2 = 111000 b1 b0) programs level 2 when b1 = 0 and level 1 when b0 = 0. A programmed bit stays programmed until a chip erase.
- R9: With level 1 programmed, writes issue no request. With both levels programmed, reads issue no request and reply 00h.
- R10: Any byte-1/byte-2 combination not listed issues no request and replies 00h.
- R11: After reset, SDO is 0, no request is active and the block is not enabled.
- R12: Each frame issues at most one request, and each request lasts one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCK |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prog_mode_i | input | 1 | High while the device is held in programming mode |
| sck_i | input | 1 | Serial shift clock from the programmer |
| sdi_i | input | 1 | Serial command/data in |
| sdo_o | output | 1 | Serial reply out |
| mem_rd_o | output | 1 | Read request pulse |
| mem_wr_o | output | 1 | Write request pulse |
| mem_erase_o | output | 1 | Full erase request pulse |
| mem_space_o | output | 1 | 0 = code array, 1 = data array |
| mem_addr_o | output | DATA_AW (17) | Request address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after mem_rd_o |

## Verification
The bench builds the block with the default widths: 12-bit code addresses, 17-bit data addresses and two synchronizer stages. These widths put the data-space top bit, carried in byte 1, within reach, as well as the full upper nibble of the code address. Eight system clocks per SCK half period give the reply path its full register latency before the first reply bit is sampled. Together these let one session cover enable gating, both protection levels, erase recovery and realignment after a mode exit.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam logic [7:0] CTRL_PFX   = 8'hAC;
  localparam logic [7:0] ENA_KEY    = 8'h53;
  localparam logic [7:0] ERASE_KEY  = 8'h80;
  localparam logic [5:0] LOCK_TOP   = 6'b111000;
  localparam logic [6:0] OPC_CODE_RD = 7'h10;
  localparam logic [6:0] OPC_CODE_WR = 7'h20;
  localparam logic [6:0] OPC_DATA_RD = 7'h50;
  localparam logic [6:0] OPC_DATA_WR = 7'h60;
  localparam logic [6:0] OPC_SIG     = 7'h18;
  localparam logic [6:0] SIG_OFS0 = 7'h30;
  localparam logic [7:0] SIG_VAL0 = 8'h1E;
  localparam logic [6:0] SIG_OFS1 = 7'h31;
  localparam logic [7:0] SIG_VAL1 = 8'h84;

  typedef enum logic [3:0] {
    OP_NONE, OP_CODE_RD, OP_CODE_WR, OP_DATA_RD, OP_DATA_WR,
    OP_SIG, OP_ENABLE, OP_ERASE, OP_LOCK
  } isp_op_e;
endpackage

// File: rtl/isp_shift.sv
module isp_shift #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       sck_i,
  input  logic       sdi_i,
  input  logic       tx_load_i,
  input  logic [7:0] tx_data_i,
  output logic       byte_done_o,
  output logic [1:0] byte_idx_o,
  output logic [7:0] byte_o,
  output logic       sdo_o
);
  logic [SYNC_STAGES:0]   sck_sync;
  logic [SYNC_STAGES-1:0] sdi_sync;
  logic [2:0] bit_cnt_q;
  logic [1:0] byte_cnt_q;
  logic [7:0] rx_q, tx_q, byte_q;
  logic [1:0] byte_idx_q;
  logic       byte_done_q;
  logic       sck_rise, sck_fall, sdi_s;

  assign sck_rise = sck_sync[SYNC_STAGES-1] & ~sck_sync[SYNC_STAGES];
  assign sck_fall = ~sck_sync[SYNC_STAGES-1] & sck_sync[SYNC_STAGES];
  assign sdi_s    = sdi_sync[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_sync    <= '0;
      sdi_sync    <= '0;
      bit_cnt_q   <= '0;
      byte_cnt_q  <= '0;
      rx_q        <= '0;
      tx_q        <= '0;
      byte_q      <= '0;
      byte_idx_q  <= '0;
      byte_done_q <= 1'b0;
    end else begin
      sck_sync    <= {sck_sync[SYNC_STAGES-1:0], sck_i};
      sdi_sync    <= {sdi_sync[SYNC_STAGES-2:0], sdi_i};
      byte_done_q <= 1'b0;
      if (!active_i) begin
        bit_cnt_q  <= '0;
        byte_cnt_q <= '0;
        rx_q       <= '0;
        tx_q       <= '0;
      end else begin
        if (sck_rise) begin
          rx_q      <= {rx_q[6:0], sdi_s};
          bit_cnt_q <= bit_cnt_q + 3'd1;
          if (bit_cnt_q == 3'd7) begin
            byte_done_q <= 1'b1;
            byte_q      <= {rx_q[6:0], sdi_s};
            byte_idx_q  <= byte_cnt_q;
            byte_cnt_q  <= byte_cnt_q + 2'd1;
          end
        end
        // the falling edge that closes byte 3 must not shift the fresh reply
        if (tx_load_i) tx_q <= tx_data_i;
        else if (sck_fall && bit_cnt_q != 3'd0) tx_q <= {tx_q[6:0], 1'b0};
      end
    end
  end

  assign byte_done_o = byte_done_q;
  assign byte_idx_o  = byte_idx_q;
  assign byte_o      = byte_q;
  assign sdo_o       = active_i && (byte_cnt_q == 2'd3) && tx_q[7];

  // R3
  mode_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (bit_cnt_q == 3'd0 && byte_cnt_q == 2'd0));
  // R1
  byte_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_q |-> (byte_cnt_q == byte_idx_q + 2'd1));
endmodule

// File: rtl/isp_decode.sv
module isp_decode
  import isp_pkg::*;
#(
  parameter int         CODE_AW   = 12,
  parameter int         DATA_AW   = 17,
  parameter logic [6:0] CODE_RD_OP = OPC_CODE_RD,
  parameter logic [6:0] CODE_WR_OP = OPC_CODE_WR,
  parameter logic [6:0] DATA_RD_OP = OPC_DATA_RD,
  parameter logic [6:0] DATA_WR_OP = OPC_DATA_WR,
  parameter logic [6:0] SIG_OP     = OPC_SIG
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               active_i,
  input  logic               byte_done_i,
  input  logic [1:0]         byte_idx_i,
  input  logic [7:0]         byte_i,
  output logic               tx_load_o,
  output logic [7:0]         tx_data_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic               mem_erase_o,
  output logic               mem_space_o,
  output logic [DATA_AW-1:0] mem_addr_o,
  output logic [7:0]         mem_wdata_o,
  input  logic [7:0]         mem_rdata_i
);
  logic [7:0] b1_q, b2_q, imm_q, wdata_q;
  logic       en_q, lk1_q, lk2_q;
  logic       rd_q, wr_q, er_q, space_q, ld1_q, ld2_q, src_mem_q;
  logic [DATA_AW-1:0] addr_q;
  isp_op_e    op;
  logic [15:0] code_full;
  logic [16:0] data_full;

  function automatic isp_op_e decode(input logic [7:0] c1, input logic [7:0] c2);
    if (c1 == CTRL_PFX) begin
      if (c2 == ENA_KEY)               return OP_ENABLE;
      else if (c2 == ERASE_KEY)        return OP_ERASE;
      else if (c2[7:2] == LOCK_TOP)    return OP_LOCK;
      else                             return OP_NONE;
    end
    if (c1[7:1] == CODE_RD_OP) return OP_CODE_RD;
    if (c1[7:1] == CODE_WR_OP) return OP_CODE_WR;
    if (c1[7:1] == DATA_RD_OP) return OP_DATA_RD;
    if (c1[7:1] == DATA_WR_OP) return OP_DATA_WR;
    if (c1[7:1] == SIG_OP)     return OP_SIG;
    return OP_NONE;
  endfunction

  function automatic logic [7:0] sig_byte(input logic [6:0] ofs);
    if (ofs == SIG_OFS0) return SIG_VAL0;
    if (ofs == SIG_OFS1) return SIG_VAL1;
    return 8'h00;
  endfunction

  assign op        = decode(b1_q, b2_q);
  assign code_full = {b2_q, byte_i};
  assign data_full = {b1_q[0], b2_q, byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b1_q <= '0; b2_q <= '0; imm_q <= '0; wdata_q <= '0;
      en_q <= 1'b0; lk1_q <= 1'b0; lk2_q <= 1'b0;
      rd_q <= 1'b0; wr_q <= 1'b0; er_q <= 1'b0; space_q <= 1'b0;
      ld1_q <= 1'b0; ld2_q <= 1'b0; src_mem_q <= 1'b0;
      addr_q <= '0;
    end else begin
      rd_q  <= 1'b0;
      wr_q  <= 1'b0;
      er_q  <= 1'b0;
      ld1_q <= 1'b0;
      ld2_q <= ld1_q;
      if (!active_i) begin
        en_q <= 1'b0;
      end else if (byte_done_i) begin
        unique case (byte_idx_i)
          2'd0: b1_q <= byte_i;
          2'd1: b2_q <= byte_i;
          2'd2: begin
            ld1_q     <= 1'b1;
            src_mem_q <= 1'b0;
            imm_q     <= 8'h00;
            if (op == OP_CODE_RD || op == OP_CODE_WR) begin
              space_q <= 1'b0;
              addr_q  <= DATA_AW'(code_full[CODE_AW-1:0]);
            end else begin
              space_q <= 1'b1;
              addr_q  <= data_full[DATA_AW-1:0];
            end
            if (en_q && !(lk1_q && lk2_q) && (op == OP_CODE_RD || op == OP_DATA_RD)) begin
              rd_q      <= 1'b1;
              src_mem_q <= 1'b1;
            end
            if (en_q && op == OP_SIG) imm_q <= sig_byte(byte_i[6:0]);
          end
          default: begin
            wdata_q <= byte_i;
            case (op)
              OP_ENABLE: en_q <= 1'b1;
              OP_CODE_WR, OP_DATA_WR: if (en_q && !lk1_q) wr_q <= 1'b1;
              OP_ERASE: if (en_q) begin
                er_q  <= 1'b1;
                lk1_q <= 1'b0;
                lk2_q <= 1'b0;
              end
              OP_LOCK: if (en_q) begin
                if (!b2_q[0]) lk1_q <= 1'b1;
                if (!b2_q[1]) lk2_q <= 1'b1;
              end
              default: ;
            endcase
          end
        endcase
      end
    end
  end

  assign tx_load_o   = ld2_q;
  assign tx_data_o   = src_mem_q ? mem_rdata_i : imm_q;
  assign mem_rd_o    = rd_q;
  assign mem_wr_o    = wr_q;
  assign mem_erase_o = er_q;
  assign mem_space_o = space_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;

  // R12
  one_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({rd_q, wr_q, er_q}) <= 1);
  // R12
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_q || wr_q || er_q) |=> !(rd_q || wr_q || er_q));
  // R2
  rd_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q |-> en_q);
  // R9
  wr_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |-> !lk1_q);
  // R8
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(lk1_q) || $fell(lk2_q)) |-> er_q);
  // R7
  erase_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    er_q |-> (!lk1_q && !lk2_q));
endmodule

// File: rtl/isp_cmd_decoder.sv
module isp_cmd_decoder #(
  parameter int CODE_AW     = 12,
  parameter int DATA_AW     = 17,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               prog_mode_i,
  input  logic               sck_i,
  input  logic               sdi_i,
  output logic               sdo_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic               mem_erase_o,
  output logic               mem_space_o,
  output logic [DATA_AW-1:0] mem_addr_o,
  output logic [7:0]         mem_wdata_o,
  input  logic [7:0]         mem_rdata_i
);
  logic       byte_done, tx_load;
  logic [1:0] byte_idx;
  logic [7:0] byte_val, tx_data;

  isp_shift #(.SYNC_STAGES(SYNC_STAGES)) i_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (prog_mode_i),
    .sck_i       (sck_i),
    .sdi_i       (sdi_i),
    .tx_load_i   (tx_load),
    .tx_data_i   (tx_data),
    .byte_done_o (byte_done),
    .byte_idx_o  (byte_idx),
    .byte_o      (byte_val),
    .sdo_o       (sdo_o)
  );

  isp_decode #(.CODE_AW(CODE_AW), .DATA_AW(DATA_AW)) i_decode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (prog_mode_i),
    .byte_done_i (byte_done),
    .byte_idx_i  (byte_idx),
    .byte_i      (byte_val),
    .tx_load_o   (tx_load),
    .tx_data_o   (tx_data),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_erase_o (mem_erase_o),
    .mem_space_o (mem_space_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i)
  );
endmodule

// File: tb/test_isp_cmd_decoder.sv
module test_isp_cmd_decoder;
  localparam int HALF = 8;
  localparam int NVEC = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_mode = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic sdo, mem_rd, mem_wr, mem_erase, mem_space;
  logic [16:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;

  int checks = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, er_cnt = 0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        wr_space = 1'b0;

  always #5 clk = ~clk;

  isp_cmd_decoder #(.CODE_AW(12), .DATA_AW(17), .SYNC_STAGES(2)) i_isp_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .prog_mode_i(prog_mode), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_erase_o(mem_erase),
    .mem_space_o(mem_space), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata)
  );

  function automatic logic [7:0] model(input logic sp, input logic [16:0] a);
    if (sp) return a[7:0] ^ a[15:8] ^ {7'b0, a[16]} ^ 8'h5A;
    return a[7:0] ^ {a[11:8], 4'h0} ^ 8'hC3;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= model(mem_space, mem_addr);
      rd_cnt <= rd_cnt + 1;
    end
    if (mem_wr) begin
      wr_cnt <= wr_cnt + 1;
      wr_addr <= mem_addr;
      wr_data <= mem_wdata;
      wr_space <= mem_space;
    end
    if (mem_erase) er_cnt <= er_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] cmd, input int nbits, output logic [7:0] rd);
    rd = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      sdi = cmd[31-i];
      repeat (HALF) @(negedge clk);
      if (i >= 24) rd = {rd[6:0], sdo};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (20) @(negedge clk);
  endtask

  // {req[3:0], cmd[31:0], exp_byte[7:0], rd, wr, er}; rd=1 -> reply from memory model
  localparam logic [46:0] VEC [NVEC] = '{
    {4'd2,  32'h2005_6700, 8'h00, 3'b000}, // R2 read before enable
    {4'd2,  32'hAC53_0000, 8'h00, 3'b000}, // R2 enable
    {4'd4,  32'h2005_6700, 8'h00, 3'b100}, // R4 code read
    {4'd5,  32'hA123_4500, 8'h00, 3'b100}, // R5 data read, top bit set
    {4'd4,  32'h400A_BC3C, 8'h00, 3'b010}, // R4 code write
    {4'd5,  32'hC1FF_0199, 8'h00, 3'b010}, // R5 data write
    {4'd6,  32'h3000_3000, 8'h1E, 3'b000}, // R6 R1
    {4'd6,  32'h3000_3100, 8'h84, 3'b000}, // R6 R1
    {4'd6,  32'h3000_3200, 8'h00, 3'b000}, // R6 other offset
    {4'd10, 32'h7700_0000, 8'h00, 3'b000}, // R10 unknown
    {4'd8,  32'hACE2_0000, 8'h00, 3'b000}, // R8 level 1
    {4'd9,  32'h4000_0155, 8'h00, 3'b000}, // R9 write blocked
    {4'd9,  32'h2000_1000, 8'h00, 3'b100}, // R9 read still allowed
    {4'd8,  32'hACE1_0000, 8'h00, 3'b000}, // R8 level 2
    {4'd9,  32'hA000_1000, 8'h00, 3'b000}, // R9 read blocked
    {4'd7,  32'hAC80_0000, 8'h00, 3'b001}, // R7 erase
    {4'd7,  32'h4000_0155, 8'h00, 3'b010}, // R7 write allowed again
    {4'd7,  32'hA000_1000, 8'h00, 3'b100}  // R7 read allowed again
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 sdo", {31'b0, sdo}, 0);
    chk("R11 req", {29'b0, mem_rd, mem_wr, mem_erase}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 sdo after release", {31'b0, sdo}, 0);
    prog_mode = 1'b1;
    repeat (4) @(negedge clk);

    for (int k = 0; k < NVEC; k++) begin
      logic [46:0] v;
      logic [31:0] cmd;
      logic        sp;
      logic [16:0] ad;
      logic [7:0]  exp;
      int r0, w0, e0;
      v = VEC[k];
      cmd = v[42:11];
      sp = cmd[31];
      ad = sp ? {cmd[24], cmd[23:8]} : {5'b0, cmd[19:8]};
      exp = v[2] ? model(sp, ad) : v[10:3];
      r0 = rd_cnt; w0 = wr_cnt; e0 = er_cnt;
      send(cmd, 32, rd);
      chk($sformatf("R%0d row %0d reply", v[46:43], k), {24'b0, rd}, {24'b0, exp});
      chk($sformatf("R12 row %0d rd count", k), rd_cnt - r0, {31'b0, v[2]});
      chk($sformatf("R12 row %0d wr count", k), wr_cnt - w0, {31'b0, v[1]});
      chk($sformatf("R12 row %0d erase count", k), er_cnt - e0, {31'b0, v[0]});
      if (v[1]) begin
        chk($sformatf("R%0d row %0d wr addr", v[46:43], k), {15'b0, wr_addr}, {15'b0, ad});
        chk($sformatf("R%0d row %0d wr data", v[46:43], k), {24'b0, wr_data}, {24'b0, cmd[7:0]});
        chk($sformatf("R%0d row %0d wr space", v[46:43], k), {31'b0, wr_space}, {31'b0, sp});
      end
    end

    // R1 SDO is 0 outside the reply byte
    chk("R1 sdo idle", {31'b0, sdo}, 0);

    // R3 partial frame then mode exit: enable lost, framing realigned
    send(32'hAC53_0000, 12, rd);
    prog_mode = 1'b0;
    repeat (10) @(negedge clk);
    prog_mode = 1'b1;
    repeat (4) @(negedge clk);
    begin
      int r0;
      r0 = rd_cnt;
      send(32'h2000_1000, 32, rd);
      chk("R3 not enabled after exit reply", {24'b0, rd}, 0);
      chk("R3 not enabled after exit rd count", rd_cnt - r0, 0);
    end
    send(32'hAC53_0000, 32, rd);
    send(32'h3000_3100, 32, rd);
    chk("R3 realigned signature", {24'b0, rd}, 32'h84);
    send(32'h3000_3000, 32, rd);
    chk("R1 MSB-first reply", {24'b0, rd}, 32'h1E);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule